// File: doc/BRIEF.md
# Serial Lane High-Speed Burst Sequencer

This block is the transmit-side controller for one data lane of a serial link that has a low-power signalling mode and a high-speed mode. While idle the lane rests in the Stop state (LP-11). A burst request starts a fixed sequence of line states. The lane first raises a high-speed request (LP-01) and then bridges through LP-00. Next it drives differential zero (HS-0), sends a sync byte, and streams the payload bytes one per reference-clock cycle. A trailer then drives the differential state opposite to the final bit. Last, the lane returns to LP-11 and holds it for an exit interval. The length of each timed phase is set by a cycle-count input. Those inputs are captured when the burst is accepted.

The state machine has eight named states. STOP is idle. HSREQ drives LP-01, BRIDGE drives LP-00 and ZERO drives HS-0. SYNC sends the sync byte, DATA streams the payload, TRAIL drives the trailer and EXIT drives LP-11. The transitions are as follows. STOP goes to HSREQ when a request is accepted. HSREQ goes to BRIDGE, BRIDGE to ZERO, ZERO to SYNC, TRAIL to EXIT and EXIT to STOP, each when the phase timer expires. SYNC goes to DATA unconditionally after one cycle. DATA goes to TRAIL when a byte marked last is accepted. An asynchronous active-low reset returns the block to STOP from any state.

Top module: `lane_burst_seq`

## Requirements
- R1: After reset the lane is in Stop. line_code is LP-11 (code 0), lane_ready is 1, and tx_ready, lane_done and hs_byte are 0.
- R2: burst_req is acted on only when it is sampled high at a clock edge while lane_ready is 1. A request raised or held at any other time has no effect on the sequence.
- R3: After acceptance the lane drives LP-01 (code 1) for t_lpx cycles. A programmed value of 0 counts as 1 in every timed phase.
- R4: The lane then drives LP-00 (code 2) for the larger of t_prepare and t_lpx cycles.
- R5: The lane then drives HS-0 (code 3) for t_zero cycles.
- R6: For exactly one cycle after HS-0, line_code is HS data (code 5) and hs_byte is the sync byte 8'hB8. tx_ready is 0 during that cycle.
- R7: In the payload phase tx_ready is 1. A cycle with tx_valid high puts tx_data on hs_byte with code 5 in the same cycle. A cycle with tx_valid low drives HS-0 (code 3) as filler.
- R8: Accepting a byte with tx_last set ends the payload phase. Bytes are serialised LSB first, so bit 7 is the last bit on the line. For t_trail cycles the lane drives HS-1 (code 4) if that bit was 0, or HS-0 (code 3) if it was 1.
- R9: After the trailer the lane drives LP-11 with lane_ready low for the larger of t_exit and t_lpx cycles. lane_done is high in the final of those cycles only, and the next cycle is Stop.
- R10: The timing inputs are captured at acceptance. Changing them during a burst does not alter any phase length of that burst.
- R11: hs_byte is 0 whenever line_code is not 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_req | input | 1 | Request to start a high-speed burst |
| t_lpx | input | CNT_W | Low-power period length in cycles |
| t_prepare | input | CNT_W | LP-00 bridge length in cycles |
| t_zero | input | CNT_W | HS-0 lead-in length in cycles |
| t_trail | input | CNT_W | Trailer length in cycles |
| t_exit | input | CNT_W | Post-burst LP-11 hold in cycles |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte valid |
| tx_last | input | 1 | Marks the final payload byte |
| tx_ready | output | 1 | Payload byte accepted this cycle when valid |
| line_code | output | 3 | Line state: 0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 HS-1, 5 HS data |
| hs_byte | output | 8 | Byte on the lane when line_code is 5 |
| lane_ready | output | 1 | Lane in Stop and able to accept a request |
| lane_done | output | 1 | Last cycle of the exit hold |

## Verification
An accepted request shows up as LP-01 in the cycle right after the accepting edge. From then on every phase follows the previous one without a gap, so the bench can count the expected line state for each cycle from the captured counts. Payload outputs (hs_byte, code 5, tx_ready) respond to tx_valid and tx_data combinationally in the same cycle. The bench therefore drives inputs on the falling edge, waits a short delay and samples in the same half cycle. It checks every cycle of each burst against the length it expects, including the lane_done pulse in the last exit cycle and the Stop state one cycle later.

// File: rtl/lane_burst_pkg.sv
package lane_burst_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;

    typedef enum logic [2:0] {
        LC_LP11    = 3'd0,
        LC_LP01    = 3'd1,
        LC_LP00    = 3'd2,
        LC_HS0     = 3'd3,
        LC_HS1     = 3'd4,
        LC_HS_DATA = 3'd5
    } line_code_e;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_HSREQ,
        ST_BRIDGE,
        ST_ZERO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_EXIT
    } seq_state_e;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lane_line_encoder.sv
module lane_line_encoder
    import lane_burst_pkg::*;
(
    input  seq_state_e        state,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              trail_one,
    output logic [2:0]        line_code,
    output logic [BYTE_W-1:0] hs_byte,
    output logic              tx_ready,
    output logic              lane_ready
);

    always_comb begin
        line_code  = LC_LP11;
        hs_byte    = '0;
        tx_ready   = 1'b0;
        lane_ready = 1'b0;
        unique case (state)
            ST_STOP: begin
                lane_ready = 1'b1;
            end
            ST_HSREQ:  line_code = LC_LP01;
            ST_BRIDGE: line_code = LC_LP00;
            ST_ZERO:   line_code = LC_HS0;
            ST_SYNC: begin
                line_code = LC_HS_DATA;
                hs_byte   = SYNC_BYTE;
            end
            ST_DATA: begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    line_code = LC_HS_DATA;
                    hs_byte   = tx_data;
                end else begin
                    line_code = LC_HS0;
                end
            end
            ST_TRAIL:  line_code = trail_one ? LC_HS1 : LC_HS0;
            ST_EXIT:   line_code = LC_LP11;
            default:   line_code = LC_LP11;
        endcase
    end

endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
    import lane_burst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_req,
    input  logic [CNT_W-1:0] t_lpx,
    input  logic [CNT_W-1:0] t_prepare,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_trail,
    input  logic [CNT_W-1:0] t_exit,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    input  logic             tx_last,
    output logic             tx_ready,
    output logic [2:0]       line_code,
    output logic [7:0]       hs_byte,
    output logic             lane_ready,
    output logic             lane_done
);

    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [CNT_W-1:0] wider(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] lpx_q, prep_q, zero_q, trail_q, exit_q;
    logic             trail_one_q;
    logic             accept, last_take;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    // Next-state selection
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        last_take = 1'b0;
        unique case (state_q)
            ST_STOP: if (burst_req) begin
                state_d = ST_HSREQ;
                accept  = 1'b1;
            end
            ST_HSREQ:  if (tmr_expired) state_d = ST_BRIDGE;
            ST_BRIDGE: if (tmr_expired) state_d = ST_ZERO;
            ST_ZERO:   if (tmr_expired) state_d = ST_SYNC;
            ST_SYNC:   state_d = ST_DATA;
            ST_DATA: if (tx_valid && tx_last) begin
                state_d   = ST_TRAIL;
                last_take = 1'b1;
            end
            ST_TRAIL:  if (tmr_expired) state_d = ST_EXIT;
            ST_EXIT:   if (tmr_expired) state_d = ST_STOP;
            default:   state_d = ST_STOP;
        endcase
    end

    // Phase length loaded on entry to each timed state
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_HSREQ:  tmr_val = span(t_lpx) - 1'b1;
            ST_BRIDGE: tmr_val = wider(span(prep_q), span(lpx_q)) - 1'b1;
            ST_ZERO:   tmr_val = span(zero_q) - 1'b1;
            ST_TRAIL:  tmr_val = span(trail_q) - 1'b1;
            ST_EXIT:   tmr_val = wider(span(exit_q), span(lpx_q)) - 1'b1;
            default:   tmr_val = '0;
        endcase
    end

    // State register and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_STOP;
            lpx_q       <= '0;
            prep_q      <= '0;
            zero_q      <= '0;
            trail_q     <= '0;
            exit_q      <= '0;
            trail_one_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lpx_q   <= t_lpx;
                prep_q  <= t_prepare;
                zero_q  <= t_zero;
                trail_q <= t_trail;
                exit_q  <= t_exit;
            end
            if (last_take) begin
                trail_one_q <= ~tx_data[7];
            end
        end
    end

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lane_line_encoder u_enc (
        .state      (state_q),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .trail_one  (trail_one_q),
        .line_code  (line_code),
        .hs_byte    (hs_byte),
        .tx_ready   (tx_ready),
        .lane_ready (lane_ready)
    );

    assign lane_done = (state_q == ST_EXIT) && tmr_expired;

endmodule

// File: rtl/lane_burst_seq_checker.sv
module lane_burst_seq_checker
    import lane_burst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       burst_req,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_ready,
    input logic [2:0] line_code,
    input logic [7:0] hs_byte,
    input logic       lane_ready,
    input logic       lane_done
);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ready |-> (line_code == LC_LP11 && !tx_ready && !lane_done));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ready && burst_req) |=> (line_code == LC_LP01 && !lane_ready));

    assert_req_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code == LC_LP01) |=> (line_code == LC_LP01 || line_code == LC_LP00));

    assert_bridge_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code == LC_LP00) |=> (line_code == LC_LP00 || line_code == LC_HS0));

    assert_sync_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code == LC_HS0 && !tx_ready) |=>
            (!tx_ready && (line_code != LC_HS_DATA || hs_byte == SYNC_BYTE)));

    assert_ready_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (line_code == LC_HS0 || line_code == LC_HS_DATA));

    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=>
            (!tx_ready && (line_code == LC_HS0 || line_code == LC_HS1)));

    assert_done_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_done |=> (lane_ready && !lane_done));

    assert_byte_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code != LC_HS_DATA) |-> (hs_byte == 8'h00));

endmodule

bind lane_burst_seq lane_burst_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_req  (burst_req),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .line_code  (line_code),
    .hs_byte    (hs_byte),
    .lane_ready (lane_ready),
    .lane_done  (lane_done)
);

// File: tb/lane_burst_seq_bench.sv
module lane_burst_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    localparam logic [2:0] C_LP11 = 3'd0, C_LP01 = 3'd1, C_LP00 = 3'd2,
                           C_HS0  = 3'd3, C_HS1  = 3'd4, C_DATA = 3'd5;

    typedef struct packed {
        logic [7:0] lpx;
        logic [7:0] prep;
        logic [7:0] zero;
        logic [7:0] trail;
        logic [7:0] ext;
        logic [7:0] nb;
        logic [7:0] seed;
        logic       gap;
        logic       hold;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 8'd4, 8'd6, 8'd5, 8'd7, 8'd3, 8'h10, 1'b0, 1'b0},
        '{8'd2, 8'd5, 8'd1, 8'd2, 8'd3, 8'd1, 8'h80, 1'b0, 1'b0},
        '{8'd6, 8'd2, 8'd0, 8'd1, 8'd2, 8'd4, 8'h11, 1'b1, 1'b0},
        '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd2, 8'hF0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             burst_req = 1'b0;
    logic [CNT_W-1:0] t_lpx = '0, t_prepare = '0, t_zero = '0, t_trail = '0, t_exit = '0;
    logic [7:0]       tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_last = 1'b0;
    logic             tx_ready;
    logic [2:0]       line_code;
    logic [7:0]       hs_byte;
    logic             lane_ready;
    logic             lane_done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_burst_seq #(.CNT_W(CNT_W)) u_lane_burst_seq (
        .clk(clk), .rst_n(rst_n), .burst_req(burst_req),
        .t_lpx(t_lpx), .t_prepare(t_prepare), .t_zero(t_zero),
        .t_trail(t_trail), .t_exit(t_exit),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .line_code(line_code), .hs_byte(hs_byte),
        .lane_ready(lane_ready), .lane_done(lane_done)
    );

    function automatic int span(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic expect_out(input logic [2:0] c, input logic [7:0] b, input logic tr,
                              input logic lr, input logic dn, input string tag);
        checks++;
        if (line_code !== c || hs_byte !== b || tx_ready !== tr ||
            lane_ready !== lr || lane_done !== dn) begin
            fails++;
            $display("FAIL %s: code/byte/txr/rdy/done got %0d/%h/%b/%b/%b expected %0d/%h/%b/%b/%b",
                     tag, line_code, hs_byte, tx_ready, lane_ready, lane_done,
                     c, b, tr, lr, dn);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic run_burst(input vec_t v);
        int         n_lpx, n_bridge, n_zero, n_trail, n_exit;
        logic [7:0] last_b;
        n_lpx    = span(v.lpx);
        n_bridge = (span(v.prep) > n_lpx) ? span(v.prep) : n_lpx;
        n_zero   = span(v.zero);
        n_trail  = span(v.trail);
        n_exit   = (span(v.ext) > n_lpx) ? span(v.ext) : n_lpx;
        last_b   = 8'h00;

        @(negedge clk);
        t_lpx = v.lpx; t_prepare = v.prep; t_zero = v.zero;
        t_trail = v.trail; t_exit = v.ext;
        burst_req = 1'b1;
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R1 stop before accept");

        for (int i = 0; i < n_lpx; i++) begin
            @(negedge clk);
            if (i == 0) begin
                // R10: clobber timing inputs after acceptance
                t_lpx = 8'd40; t_prepare = 8'd40; t_zero = 8'd40;
                t_trail = 8'd40; t_exit = 8'd40;
                burst_req = v.hold;
            end
            #1 expect_out(C_LP01, 8'h00, 1'b0, 1'b0, 1'b0, "R3 LP-01 request R10");
        end
        for (int i = 0; i < n_bridge; i++) begin
            @(negedge clk);
            #1 expect_out(C_LP00, 8'h00, 1'b0, 1'b0, 1'b0, "R4 LP-00 bridge");
        end
        for (int i = 0; i < n_zero; i++) begin
            @(negedge clk);
            #1 expect_out(C_HS0, 8'h00, 1'b0, 1'b0, 1'b0, "R5 HS-0 lead-in");
        end
        @(negedge clk);
        #1 expect_out(C_DATA, 8'hB8, 1'b0, 1'b0, 1'b0, "R6 sync byte");

        for (int i = 0; i < int'(v.nb); i++) begin
            if (v.gap && i == 1) begin
                @(negedge clk);
                tx_valid = 1'b0; tx_last = 1'b0; tx_data = 8'hAA;
                #1 expect_out(C_HS0, 8'h00, 1'b1, 1'b0, 1'b0, "R7 filler R11");
            end
            @(negedge clk);
            tx_data  = v.seed + 8'(i * 37);
            tx_valid = 1'b1;
            tx_last  = (i == int'(v.nb) - 1);
            last_b   = tx_data;
            #1 expect_out(C_DATA, tx_data, 1'b1, 1'b0, 1'b0, "R7 payload");
        end
        for (int i = 0; i < n_trail; i++) begin
            @(negedge clk);
            tx_valid = 1'b0; tx_last = 1'b0;
            #1 expect_out(last_b[7] ? C_HS0 : C_HS1, 8'h00, 1'b0, 1'b0, 1'b0, "R8 trailer");
        end
        for (int i = 0; i < n_exit; i++) begin
            @(negedge clk);
            if (i == n_exit - 1) burst_req = 1'b0;
            #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b0, (i == n_exit - 1), "R9 exit hold R2");
        end
        @(negedge clk);
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R9 back to stop");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R1 reset state");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2: no request, payload activity ignored while in Stop
        @(negedge clk);
        tx_valid = 1'b1; tx_last = 1'b1; tx_data = 8'h5C;
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R2 idle ignores payload");
        @(negedge clk);
        tx_valid = 1'b0; tx_last = 1'b0;
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R2 no request stays in stop");

        // Table-driven bursts
        for (int k = 0; k < NV; k++) begin
            run_burst(VECS[k]);
        end

        // R1: reset in the middle of a burst returns to Stop
        @(negedge clk);
        t_lpx = 8'd2; t_prepare = 8'd2; t_zero = 8'd4; t_trail = 8'd2; t_exit = 8'd2;
        burst_req = 1'b1;
        @(negedge clk);
        burst_req = 1'b0;
        #1 expect_out(C_LP01, 8'h00, 1'b0, 1'b0, 1'b0, "R3 request before reset");
        repeat (4) @(negedge clk);
        #1 expect_out(C_HS0, 8'h00, 1'b0, 1'b0, 1'b0, "R5 lead-in before reset");
        rst_n = 1'b0;
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R1 reset mid-burst");
        @(negedge clk);
        rst_n = 1'b1;
        #1 expect_out(C_LP11, 8'h00, 1'b0, 1'b1, 1'b0, "R1 stop after reset");

        finish_run();
    end

endmodule